// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block decides which interrupt a processor should service next and hands the handler address to the software that asks for it. It keeps sixteen vector slots. Each slot has a control byte, which names one of up to 32 interrupt sources and can turn the slot on or off, and a handler address. A separate default handler address covers every source that no enabled slot claims. Slot 0 has the highest rank and slot 15 the lowest. The unvectored sources rank below all slots, as level 16.

Two 32-bit source words come from a routing bank upstream. The raw word carries every asserted source. The masked word carries only the sources that are enabled for the normal interrupt line. The block drives a registered interrupt request whenever a masked source outranks the level now in service.

Software reads the vector register when it enters a handler. The read returns the handler address and moves the service level up to that of the winning source. Software writes the vector register when it leaves the handler, and the write returns the block to the level it was at before. The block keeps one saved level per priority level, so nested handlers unwind in order.

Top module: `vic_prio_resolver`

## Requirements
- R1: After synchronous reset, every slot address, every control byte and the default address read as zero, no level is in service (service level 17), and `irq_out` is low.
- R2: Register reads return their data on `reg_rdata` at the clock edge after the read. Slot n's handler address is at byte offset 0x100+4n. Slot n's control byte is at 0x200+4n: only the low 8 bits of a write are kept, and a read returns them zero-extended. The default address is at 0x034. Any other offset reads zero. A write to any offset other than the vector register (0x030) leaves the service level unchanged.
- R3: In a control byte, bit 5 enables the slot and bits 4:0 give the source number. A disabled slot claims no source.
- R4: The mask for level i is the OR of the one-hot source bits of the enabled slots ranked above i. So the mask for level 0 is empty, the mask for level 16 covers every enabled slot, and the mask for the idle level 17 covers all sources.
- R5: `irq_out` is a register. It is set one cycle after (masked sources AND mask of the current service level) is nonzero, and cleared one cycle after it becomes zero.
- R6: A read of 0x030 searches for the smallest level i below the current service level for which (raw sources AND mask of level i+1) is nonzero. If it finds one, it returns the address of level i (the default address for level 16), saves the current level as the previous level of i, and makes i the current level.
- R7: If that search finds no level, the read returns the address of the current level, or the default address when the block is at level 16 or idle, and the service level stays as it was.
- R8: A write to 0x030 ignores its data. If a level is in service, it restores the previous level saved for the current level. When the block is idle, it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raw | input | SRC_W | Raw source levels, used by the vector search |
| src_irq | input | SRC_W | Sources masked for the interrupt line, used by `irq_out` |
| reg_wr | input | 1 | Register write strobe; if a read is strobed in the same cycle, the read is dropped |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | OFS_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench nests a higher-ranked source inside a lower one. It then unwinds one write at a time. A design that lost the saved level, or that restored to idle at once, would raise `irq_out` at the wrong moment or return the wrong slot address.

A vector read made while the block is already at the top level, or while only lower-ranked sources are pending, must return the current level's address and must not move the service level. Extra vector writes made while idle must not disturb the next search.

A disabled slot shares its source number with an enabled, lower-ranked slot. A design that ignored the enable bit would return the disabled slot's address. Finally, an unvectored source must resolve to the default address and level 16. A vectored source that arrives while level 16 is in service must still outrank it.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  // control byte layout
  localparam int CTRL_W      = 8;
  localparam int CTRL_EN_BIT = 5;
  localparam int CTRL_SRC_W  = 5;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SLOT_ADDR,
    RK_SLOT_CTRL,
    RK_DEFAULT,
    RK_VECTOR
  } reg_kind_e;
endpackage

// File: rtl/vpr_reg_decode.sv
module vpr_reg_decode
  import vpr_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int OFS_W     = 12,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int WORD_W   = OFS_W - 2
) (
  input  logic [OFS_W-1:0]  addr,
  output reg_kind_e         kind,
  output logic [SLOT_W-1:0] slot
);
  localparam int ADDR_BASE_W = 'h40;   // byte 0x100
  localparam int CTRL_BASE_W = 'h80;   // byte 0x200
  localparam int VEC_W       = 12;     // byte 0x030
  localparam int DEF_W       = 13;     // byte 0x034

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] addr_off;
  logic [WORD_W-1:0] ctrl_off;

  assign word     = addr[OFS_W-1:2];
  assign addr_off = word - WORD_W'(ADDR_BASE_W);
  assign ctrl_off = word - WORD_W'(CTRL_BASE_W);

  always_comb begin
    kind = RK_NONE;
    slot = '0;
    if (word >= WORD_W'(ADDR_BASE_W) && word < WORD_W'(ADDR_BASE_W + NUM_SLOTS)) begin
      kind = RK_SLOT_ADDR;
      slot = addr_off[SLOT_W-1:0];
    end else if (word >= WORD_W'(CTRL_BASE_W) && word < WORD_W'(CTRL_BASE_W + NUM_SLOTS)) begin
      kind = RK_SLOT_CTRL;
      slot = ctrl_off[SLOT_W-1:0];
    end else if (word == WORD_W'(VEC_W)) begin
      kind = RK_VECTOR;
    end else if (word == WORD_W'(DEF_W)) begin
      kind = RK_DEFAULT;
    end
  end
endmodule

// File: rtl/vpr_vector_store.sv
module vpr_vector_store
  import vpr_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int NUM_LVL  = NUM_SLOTS + 1,
  localparam int LVL_W    = $clog2(NUM_LVL + 1),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               addr_we,
  input  logic [LVL_W-1:0]                   addr_widx,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic                               ctrl_we,
  input  logic [SLOT_W-1:0]                  ctrl_widx,
  input  logic [LVL_W-1:0]                   rd_lvl,
  output logic [DATA_W-1:0]                  rd_addr,
  output logic [NUM_SLOTS-1:0][CTRL_W-1:0]   ctrl
);
  // Entry NUM_SLOTS is the default address. Reset clearing forces flops.
  logic [DATA_W-1:0] vec_mem [NUM_LVL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LVL; i++) vec_mem[i] <= '0;
    end else if (addr_we) begin
      vec_mem[addr_widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_we) begin
      ctrl[ctrl_widx] <= wdata[CTRL_W-1:0];
    end
  end

  assign rd_addr = vec_mem[rd_lvl];
endmodule

// File: rtl/vpr_mask_gen.sv
module vpr_mask_gen
  import vpr_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  localparam int NUM_LVL  = NUM_SLOTS + 1
) (
  input  logic [NUM_SLOTS-1:0][CTRL_W-1:0] ctrl,
  output logic [NUM_LVL:0][SRC_W-1:0]      masks
);
  logic [NUM_SLOTS-1:0][SRC_W-1:0] claim;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_claim
    assign claim[g] = ctrl[g][CTRL_EN_BIT]
                      ? (SRC_W'(1) << ctrl[g][CTRL_SRC_W-1:0])
                      : '0;
  end

  // running OR: level i sees every enabled slot ranked above it
  always_comb begin
    logic [SRC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      masks[i] = acc;
      acc      = acc | claim[i];
    end
    masks[NUM_SLOTS] = acc;
    masks[NUM_LVL]   = '1;
  end
endmodule

// File: rtl/vpr_level_stack.sv
module vpr_level_stack #(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  localparam int NUM_LVL  = NUM_SLOTS + 1,
  localparam int LVL_W    = $clog2(NUM_LVL + 1),
  localparam int IDLE     = NUM_LVL
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SRC_W-1:0]            raw,
  input  logic [NUM_LVL:0][SRC_W-1:0] masks,
  input  logic                        vec_rd,
  input  logic                        vec_wr,
  output logic [LVL_W-1:0]            prio,
  output logic [LVL_W-1:0]            sel_lvl
);
  logic [NUM_LVL-1:0] hit;
  logic               found;
  logic [LVL_W-1:0]   win;
  logic [LVL_W-1:0]   prev [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_hit
    assign hit[g] = (LVL_W'(g) < prio) && (|(raw & masks[g+1]));
  end

  // lowest-numbered hit wins
  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        win   = LVL_W'(i);
      end
    end
  end

  assign sel_lvl = found ? win
                 : ((prio > LVL_W'(NUM_SLOTS)) ? LVL_W'(NUM_SLOTS) : prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      prio <= LVL_W'(IDLE);
      for (int i = 0; i < NUM_LVL; i++) prev[i] <= LVL_W'(IDLE);
    end else if (vec_wr) begin
      if (prio != LVL_W'(IDLE)) prio <= prev[prio];
    end else if (vec_rd && found) begin
      prev[win] <= prio;
      prio      <= win;
    end
  end
endmodule

// File: rtl/vic_prio_resolver.sv
module vic_prio_resolver
  import vpr_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 32,
  parameter int DATA_W    = 32,
  parameter int OFS_W     = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_raw,
  input  logic [SRC_W-1:0]  src_irq,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int NUM_LVL = NUM_SLOTS + 1;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int IDLE    = NUM_LVL;

  reg_kind_e                       kind;
  logic [SLOT_W-1:0]               slot;
  logic                            rd_go;
  logic [NUM_SLOTS-1:0][CTRL_W-1:0] ctrl;
  logic [NUM_LVL:0][SRC_W-1:0]     masks;
  logic [LVL_W-1:0]                cur_prio;
  logic [LVL_W-1:0]                sel_lvl;
  logic [LVL_W-1:0]                rd_lvl;
  logic [LVL_W-1:0]                wr_lvl;
  logic [DATA_W-1:0]               rd_addr;
  logic [DATA_W-1:0]               rdata_d;

  assign rd_go = reg_rd & ~reg_wr;

  vpr_reg_decode #(.NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W)) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .slot (slot)
  );

  assign wr_lvl = (kind == RK_DEFAULT) ? LVL_W'(NUM_SLOTS) : LVL_W'(slot);

  always_comb begin
    case (kind)
      RK_VECTOR:  rd_lvl = sel_lvl;
      RK_DEFAULT: rd_lvl = LVL_W'(NUM_SLOTS);
      default:    rd_lvl = LVL_W'(slot);
    endcase
  end

  vpr_vector_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .addr_we   (reg_wr && (kind == RK_SLOT_ADDR || kind == RK_DEFAULT)),
    .addr_widx (wr_lvl),
    .wdata     (reg_wdata),
    .ctrl_we   (reg_wr && kind == RK_SLOT_CTRL),
    .ctrl_widx (slot),
    .rd_lvl    (rd_lvl),
    .rd_addr   (rd_addr),
    .ctrl      (ctrl)
  );

  vpr_mask_gen #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_mask (
    .ctrl  (ctrl),
    .masks (masks)
  );

  vpr_level_stack #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .raw     (src_raw),
    .masks   (masks),
    .vec_rd  (rd_go && kind == RK_VECTOR),
    .vec_wr  (reg_wr && kind == RK_VECTOR),
    .prio    (cur_prio),
    .sel_lvl (sel_lvl)
  );

  always_comb begin
    case (kind)
      RK_SLOT_ADDR, RK_DEFAULT, RK_VECTOR: rdata_d = rd_addr;
      RK_SLOT_CTRL: rdata_d = DATA_W'(ctrl[slot]);
      default:      rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (rd_go) reg_rdata <= rdata_d;
      irq_out <= |(src_irq & masks[cur_prio]);
    end
  end
endmodule

// File: rtl/vpr_prio_checker.sv
module vpr_prio_checker #(
  parameter int LVL_W = 5,
  parameter int IDLE  = 17,
  parameter int OFS_W = 12,
  parameter int SRC_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [OFS_W-1:0] reg_addr,
  input logic [SRC_W-1:0] src_irq,
  input logic             irq_out,
  input logic [LVL_W-1:0] prio
);
  logic is_vec;
  assign is_vec = (reg_addr[OFS_W-1:2] == (OFS_W-2)'(12));

  // R5
  level0_silent_chk: assert property (@(posedge clk) disable iff (rst)
    prio == '0 |=> !irq_out);
  // R5
  no_source_silent_chk: assert property (@(posedge clk) disable iff (rst)
    src_irq == '0 |=> !irq_out);
  // R6
  vec_read_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && is_vec) |=> prio <= $past(prio));
  // R8
  vec_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && is_vec && prio == LVL_W'(IDLE)) |=> prio == LVL_W'(IDLE));
  // R8
  vec_write_unwind_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && is_vec && prio != LVL_W'(IDLE)) |=> prio > $past(prio));
  // R2
  other_write_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !is_vec) |=> $stable(prio));
  // R6
  prio_range_chk: assert property (@(posedge clk) disable iff (rst)
    prio <= LVL_W'(IDLE));
endmodule

bind vic_prio_resolver vpr_prio_checker #(
  .LVL_W (LVL_W),
  .IDLE  (IDLE),
  .OFS_W (OFS_W),
  .SRC_W (SRC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .src_irq  (src_irq),
  .irq_out  (irq_out),
  .prio     (cur_prio)
);

// File: tb/vic_prio_resolver_tb.sv
module vic_prio_resolver_tb;
  localparam logic [11:0] VEC = 12'h030;
  localparam logic [11:0] DEF = 12'h034;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_raw = '0;
  logic [31:0] src_irq = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int ntests = 0;
  int nfail  = 0;
  logic rd_d = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #5 clk = ~clk;

  vic_prio_resolver u_dut (
    .clk (clk), .rst (rst), .src_raw (src_raw), .src_irq (src_irq),
    .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_out (irq_out)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] got, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data appears
  always @(posedge clk) rd_d <= reg_rd & ~reg_wr;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sbq.size() == 0) begin
        check(1'b0, "scoreboard underflow", reg_rdata, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(reg_rdata == e.exp, e.tag, reg_rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    @(negedge clk);
    sbq.push_back(e);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] r, input logic [31:0] m);
    @(negedge clk);
    src_raw = r; src_irq = m;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    @(negedge clk);
    check(irq_out == exp, tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", ntests + 1, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq low after reset");
    rd(VEC, 32'h0, "R1 vector read at idle gives cleared default");
    rd(12'h10C, 32'h0, "R1 slot address cleared");
    rd(12'h208, 32'h0, "R1 control byte cleared");

    for (int n = 0; n < 16; n++) wr(12'h100 + 12'(4 * n), 32'h1000 + 32'(16 * n));
    wr(DEF, 32'hDEAD0000);
    wr(12'h200, 32'h23);   // slot0 -> src3
    wr(12'h204, 32'h1A7);  // slot1 -> src7, high bits dropped
    wr(12'h208, 32'h09);   // slot2 src9 disabled
    wr(12'h210, 32'h29);   // slot4 -> src9
    rd(12'h114, 32'h1050, "R2 slot5 address");
    rd(12'h204, 32'hA7, "R2 control byte keeps low 8 bits");
    rd(DEF, 32'hDEAD0000, "R2 default address");
    rd(12'h040, 32'h0, "R2 unmapped offset reads zero");

    set_src(32'h80, 32'h0);
    chk_irq(1'b0, "R5 raw-only source does not request");
    set_src(32'h80, 32'h80);
    chk_irq(1'b1, "R4 idle mask covers all sources");
    rd(VEC, 32'h1010, "R6 slot1 wins from idle");
    chk_irq(1'b0, "R4 level1 mask excludes own source");

    set_src(32'h88, 32'h88);
    chk_irq(1'b1, "R4 slot0 source outranks level1");
    rd(VEC, 32'h1000, "R6 nested slot0 wins");
    chk_irq(1'b0, "R5 level0 blocks everything");
    rd(VEC, 32'h1000, "R7 no higher level at level0");

    wr(VEC, 32'hFFFFFFFF);
    chk_irq(1'b1, "R8 unwind to level1 re-exposes src3");
    set_src(32'h80, 32'h80);
    chk_irq(1'b0, "R5 level1 with only src7");
    rd(VEC, 32'h1010, "R7 no hit returns current level address");
    wr(VEC, 32'h0);
    chk_irq(1'b1, "R8 second unwind back to idle");
    wr(VEC, 32'h12345678);
    rd(VEC, 32'h1010, "R8 write at idle has no effect");
    wr(VEC, 32'h0);

    wr(12'h204, 32'h07);   // disable slot1
    chk_irq(1'b1, "R3 idle still requests");
    rd(VEC, 32'hDEAD0000, "R3 disabled slot falls to default");
    chk_irq(1'b0, "R3 level16 mask lacks disabled source");
    wr(VEC, 32'h0);

    set_src(32'h100000, 32'h100000);
    chk_irq(1'b1, "R5 unvectored source at idle");
    rd(VEC, 32'hDEAD0000, "R6 unvectored resolves to level16");
    chk_irq(1'b0, "R4 level16 masks unvectored source");
    set_src(32'h100200, 32'h100200);
    chk_irq(1'b1, "R4 vectored src9 outranks level16");
    rd(VEC, 32'h1040, "R3 enabled slot4 wins over disabled slot2");
    wr(VEC, 32'h0);
    chk_irq(1'b1, "R8 unwind to level16 keeps src9 pending");
    wr(VEC, 32'h0);
    set_src(32'h0, 32'h0);
    chk_irq(1'b0, "R5 no sources no request");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) check(1'b0, "R2 scoreboard drained", 32'(sbq.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule